// File: doc/BRIEF.md
# Multiport Repeater Control Sequencer

This block is the control state machine of a multiport Ethernet repeater. It watches a receive-activity line and a collision line from every port. When the repeater is quiet and any port starts receiving, it picks that port as the source, waits a fixed start-up interval, and then walks the transmit side through an on-chip preamble pattern, a start-of-frame delimiter slot and the repeated data. While it does so, every port other than the source is told to transmit. All timing is counted in bit times, using a one-cycle bit strobe.

Once the block leaves idle, no frame shorter than the minimum length (96 bit times by default) goes out. If the source stops early, or reports a collision, the block moves to a jam state. In that state all ports send the alternating jam pattern until the minimum is reached and the inputs are quiet. After a normal frame, the block waits for the external elasticity buffer to report empty. It then runs a transmit-recovery interval and a wait interval before it accepts new activity.

Outside the block, preamble, delimiter and data are seen as one repeat state, and wait and idle are seen as one idle state.

Top module: `rptr_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: state_code is 0, tx_en is all zero, and gen_en, sfd_en and data_en are all 0.
- R2: When any rx_act bit is high in idle, the block leaves idle. port_sel takes the lowest-numbered active port and keeps that value until the block is idle again.
- R3: A start-up interval of STARTUP_BITS bit times follows. During it, state_code is 1 and tx_en is zero.
- R4: Preamble is sent for PRE_BITS bit times. During it, gen_en is 1 and gen_bit alternates 1,0,1,... beginning with 1. Next, sfd_en is 1 for 8 bit times. After that, data_en is 1.
- R5: During preamble, delimiter and data, tx_en has a 1 for every port except port_sel, and a 0 at port_sel.
- R6: From the first transmit bit to the last, the number of bit times with tx_en non-zero equals the greater of two values: the source's activity length minus STARTUP_BITS, and MIN_BITS.
- R7: The source can drop its activity before MIN_BITS bits have been sent. In that case the block enters jam (state_code 3), drives tx_en all ones with gen_en 1, and stays there until the minimum is met.
- R8: A collision on the selected port during preamble, delimiter or data moves the block to jam. Jam ends only when the minimum is met and all rx_act and col_det bits are low.
- R9: After the source drops its activity at or past the minimum, the block stays in data until buf_empty is 1.
- R10: After transmission ends, a recovery interval of RECOV_BITS bit times follows, with state_code 4 and tx_en zero. A wait interval of WAIT_BITS bit times comes next. It shows state_code 0, and during it rx_act is ignored.
- R11: state_code encodes the visible state as follows: 0 idle/wait, 1 start-up, 2 repeat, 3 jam, 4 recovery.
- R12: While bit_en is low, the interval counters do not advance, so a timed state such as start-up does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| rx_act | input | NPORTS | Per-port receive activity |
| col_det | input | NPORTS | Per-port collision indication |
| buf_empty | input | 1 | Elasticity buffer has drained |
| tx_en | output | NPORTS | Per-port transmit enable |
| gen_en | output | 1 | Preamble/jam generator drives the transmit data |
| gen_bit | output | 1 | Current generator bit (1010 pattern) |
| sfd_en | output | 1 | Delimiter slot is being sent |
| data_en | output | 1 | Repeated receive data is being sent |
| port_sel | output | $clog2(NPORTS) | Index of the selected source port |
| state_code | output | 3 | Visible state code |

## Verification
A table of single-port and multi-port activity bursts drives the block. The multi-port masks separate lowest-index selection from any other priority. The durations are chosen to fall well above, exactly on, one bit below and far below the minimum length, which separates normal completion from fragment extension at the exact boundary. Directed runs cover four further cases:
- a stalled buffer drain;
- a collision held well past the minimum;
- a gap in the bit strobe during start-up;
- activity that arrives during the wait interval, which must be ignored.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_PRE   = 3'd2,
    S_SFD   = 3'd3,
    S_DATA  = 3'd4,
    S_JAM   = 3'd5,
    S_RECOV = 3'd6,
    S_WAIT  = 3'd7
  } rstate_e;

  localparam logic [2:0] CODE_IDLE   = 3'd0;
  localparam logic [2:0] CODE_START  = 3'd1;
  localparam logic [2:0] CODE_REPEAT = 3'd2;
  localparam logic [2:0] CODE_JAM    = 3'd3;
  localparam logic [2:0] CODE_RECOV  = 3'd4;

  localparam int SFD_LEN = 8;

  function automatic logic [2:0] ext_code(input rstate_e s);
    case (s)
      S_START:              ext_code = CODE_START;
      S_PRE, S_SFD, S_DATA: ext_code = CODE_REPEAT;
      S_JAM:                ext_code = CODE_JAM;
      S_RECOV:              ext_code = CODE_RECOV;
      default:              ext_code = CODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rptr_arb.sv
module rptr_arb #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input  logic [NPORTS-1:0] req,
  output logic [PW-1:0]     idx,
  output logic              any
);

  always_comb begin
    idx = '0;
    any = |req;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (req[i]) idx = PW'(i);
    end
  end

endmodule

// File: rtl/rptr_bit_timer.sv
module rptr_bit_timer #(
  parameter int CW       = 8,
  parameter int MIN_BITS = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          restart,
  input  logic          tx_on,
  input  logic          tx_clr,
  output logic [CW-1:0] phase,
  output logic          min_met
);

  localparam logic [CW-1:0] MIN_V  = CW'(MIN_BITS);
  localparam logic [CW-1:0] MIN_M1 = CW'(MIN_BITS - 1);

  logic [CW-1:0] phase_q, phase_d;
  logic [CW-1:0] sent_q, sent_d;

  always_comb begin
    phase_d = phase_q;
    if (restart)     phase_d = '0;
    else if (bit_en) phase_d = phase_q + 1'b1;
  end

  always_comb begin
    sent_d = sent_q;
    if (tx_clr)                                  sent_d = '0;
    else if (tx_on && bit_en && sent_q != MIN_V) sent_d = sent_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sent_q  <= '0;
    end else begin
      phase_q <= phase_d;
      sent_q  <= sent_d;
    end
  end

  assign phase   = phase_q;
  assign min_met = (sent_q == MIN_V) || (sent_q == MIN_M1 && bit_en);

endmodule

// File: rtl/rptr_ctrl.sv
module rptr_ctrl
  import rptr_pkg::*;
#(
  parameter int NPORTS       = 4,
  parameter int STARTUP_BITS = 4,
  parameter int PRE_BITS     = 56,
  parameter int MIN_BITS     = 96,
  parameter int RECOV_BITS   = 12,
  parameter int WAIT_BITS    = 8,
  localparam int PW          = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [NPORTS-1:0] rx_act,
  input  logic [NPORTS-1:0] col_det,
  input  logic              buf_empty,
  output logic [NPORTS-1:0] tx_en,
  output logic              gen_en,
  output logic              gen_bit,
  output logic              sfd_en,
  output logic              data_en,
  output logic [PW-1:0]     port_sel,
  output logic [2:0]        state_code
);

  localparam int M1     = (STARTUP_BITS > PRE_BITS) ? STARTUP_BITS : PRE_BITS;
  localparam int M2     = (RECOV_BITS > WAIT_BITS) ? RECOV_BITS : WAIT_BITS;
  localparam int M3     = (M1 > M2) ? M1 : M2;
  localparam int M4     = (M3 > SFD_LEN) ? M3 : SFD_LEN;
  localparam int MAXLEN = (M4 > MIN_BITS) ? M4 : MIN_BITS;
  localparam int CW     = $clog2(MAXLEN + 1) + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  rstate_e       state_q, state_d;
  logic [PW-1:0] sel_q;
  logic [PW-1:0] arb_idx;
  logic          arb_any;
  logic [CW-1:0] phase;
  logic          min_met;
  logic          tx_on;
  logic          rx_sel, col_sel;

  rptr_arb #(.NPORTS(NPORTS), .PW(PW)) u_arb (
    .req (rx_act),
    .idx (arb_idx),
    .any (arb_any)
  );

  assign tx_on = (state_q == S_PRE) || (state_q == S_SFD) ||
                 (state_q == S_DATA) || (state_q == S_JAM);

  rptr_bit_timer #(.CW(CW), .MIN_BITS(MIN_BITS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .bit_en  (bit_en),
    .restart (state_d != state_q),
    .tx_on   (tx_on),
    .tx_clr  (state_q == S_IDLE),
    .phase   (phase),
    .min_met (min_met)
  );

  assign rx_sel  = rx_act[sel_q];
  assign col_sel = col_det[sel_q];

  // next-state process
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (arb_any) state_d = S_START;
      S_START: if (bit_en && phase == CW'(STARTUP_BITS - 1)) state_d = S_PRE;
      S_PRE: begin
        if (col_sel || !rx_sel)                          state_d = S_JAM;
        else if (bit_en && phase == CW'(PRE_BITS - 1))   state_d = S_SFD;
      end
      S_SFD: begin
        if (col_sel || !rx_sel)                          state_d = S_JAM;
        else if (bit_en && phase == CW'(SFD_LEN - 1))    state_d = S_DATA;
      end
      S_DATA: begin
        if (col_sel)                                     state_d = S_JAM;
        else if (!rx_sel && !min_met)                    state_d = S_JAM;
        else if (!rx_sel && buf_empty)                   state_d = S_RECOV;
      end
      S_JAM:   if (min_met && !(|rx_act) && !(|col_det)) state_d = S_RECOV;
      S_RECOV: if (bit_en && phase == CW'(RECOV_BITS - 1)) state_d = S_WAIT;
      S_WAIT:  if (bit_en && phase == CW'(WAIT_BITS - 1))  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= S_IDLE;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && arb_any) sel_q <= arb_idx;
    end
  end

  // outputs
  always_comb begin
    case (state_q)
      S_PRE, S_SFD, S_DATA: tx_en = ~(NPORTS'(1) << sel_q);
      S_JAM:                tx_en = '1;
      default:              tx_en = '0;
    endcase
  end

  assign gen_en     = (state_q == S_PRE) || (state_q == S_JAM);
  assign gen_bit    = gen_en & ~phase[0];
  assign sfd_en     = (state_q == S_SFD);
  assign data_en    = (state_q == S_DATA);
  assign port_sel   = sel_q;
  assign state_code = ext_code(state_q);

endmodule

// File: rtl/rptr_ctrl_chk.sv
module rptr_ctrl_chk
  import rptr_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int MIN_BITS = 96,
  parameter int PW       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic [NPORTS-1:0] tx_en,
  input logic              gen_en,
  input logic              gen_bit,
  input logic [PW-1:0]     port_sel,
  input logic [2:0]        state_code
);

  localparam int SW = $clog2(MIN_BITS + 1) + 1;
  logic [SW-1:0] sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        sent_q <= '0;
    else if (state_code == CODE_IDLE)                  sent_q <= '0;
    else if (tx_en != '0 && bit_en && sent_q != SW'(MIN_BITS))
                                                       sent_q <= sent_q + 1'b1;
  end

  // R2
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != CODE_IDLE && $past(state_code) != CODE_IDLE) |-> $stable(port_sel));

  // R5
  p_src_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_REPEAT) |-> (tx_en[port_sel] == 1'b0 &&
                                     $countones(tx_en) == NPORTS - 1));

  // R7
  p_jam_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_JAM) |-> (tx_en == '1 && gen_en));

  // R4
  p_gen_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && $past(gen_en) && $past(bit_en) && $past(state_code) == state_code)
      |-> (gen_bit != $past(gen_bit)));

  // R6
  p_min_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_en) != '0 && tx_en == '0) |-> (sent_q == SW'(MIN_BITS)));

  // R10
  p_recov_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_RECOV) |-> (tx_en == '0));

  // R12
  p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_START && !bit_en) |=> (state_code == CODE_START));

endmodule

bind rptr_ctrl rptr_ctrl_chk #(
  .NPORTS   (NPORTS),
  .MIN_BITS (MIN_BITS),
  .PW       (PW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .tx_en      (tx_en),
  .gen_en     (gen_en),
  .gen_bit    (gen_bit),
  .port_sel   (port_sel),
  .state_code (state_code)
);

// File: tb/rptr_ctrl_bench.sv
module rptr_ctrl_bench;

  localparam int CLK_P   = 10;
  localparam int NP      = 4;
  localparam int STARTUP = 4;
  localparam int PRE     = 56;
  localparam int MINB    = 96;
  localparam int RECOV   = 12;
  localparam int WAITB   = 8;
  localparam int NCASE   = 6;

  localparam logic [NP-1:0] T_MASK [NCASE] = '{4'b0100, 4'b0110, 4'b1000, 4'b1010, 4'b0001, 4'b1111};
  localparam int            T_DUR  [NCASE] = '{150, 150, 20, 99, 100, 2};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bit_en;
  logic [NP-1:0] rx_act, col_det;
  logic          buf_empty;
  logic [NP-1:0] tx_en;
  logic          gen_en, gen_bit, sfd_en, data_en;
  logic [1:0]    port_sel;
  logic [2:0]    state_code;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  rptr_ctrl #(.NPORTS(NP), .STARTUP_BITS(STARTUP), .PRE_BITS(PRE), .MIN_BITS(MINB),
              .RECOV_BITS(RECOV), .WAIT_BITS(WAITB)) u_rptr_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_act(rx_act), .col_det(col_det),
    .buf_empty(buf_empty), .tx_en(tx_en), .gen_en(gen_en), .gen_bit(gen_bit),
    .sfd_en(sfd_en), .data_en(data_en), .port_sel(port_sel), .state_code(state_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [NP-1:0] mask, input int dur);
    int exp_sel, exp_tx, i, txc, stc, prec, sfdc, recc, selbad, exbad, gb0, gb1, npre;
    bit jam, exp_jam, recov_seen;
    exp_sel = 0;
    for (int b = NP - 1; b >= 0; b--) if (mask[b]) exp_sel = b;
    exp_tx  = (dur - STARTUP > MINB) ? dur - STARTUP : MINB;
    exp_jam = (dur - STARTUP) < MINB;
    txc = 0; stc = 0; prec = 0; sfdc = 0; recc = 0; selbad = 0; exbad = 0;
    gb0 = -1; gb1 = -1; npre = 0; jam = 0; recov_seen = 0; i = 0;
    rx_act = mask;
    while (i < 2000) begin
      @(negedge clk);
      i++;
      if (i == dur) rx_act = '0;
      if (tx_en != '0) txc++;
      if (state_code == 3'd1) stc++;
      if (state_code == 3'd3) jam = 1;
      if (state_code == 3'd4) begin recc++; recov_seen = 1; end
      if (state_code != 3'd0 && port_sel != 2'(exp_sel)) selbad++;
      if (state_code == 3'd2 && tx_en != ~(NP'(1) << exp_sel)) exbad++;
      if (state_code == 3'd2 && gen_en) begin
        prec++;
        if (npre == 0) gb0 = int'(gen_bit);
        if (npre == 1) gb1 = int'(gen_bit);
        npre++;
      end
      if (sfd_en) sfdc++;
      if (recov_seen && state_code == 3'd0) break;
    end
    rx_act = '0;
    repeat (WAITB + 1) @(negedge clk);
    chk(selbad == 0, "R2 lowest active port held", selbad, 0);
    chk(stc == STARTUP, "R3 start-up length", stc, STARTUP);
    chk(exbad == 0, "R5 source excluded from transmit", exbad, 0);
    chk(txc == exp_tx, "R6 transmitted bit times", txc, exp_tx);
    chk(jam == exp_jam, "R7 jam on short fragment", int'(jam), int'(exp_jam));
    chk(recc == RECOV, "R10 recovery length", recc, RECOV);
    if (!exp_jam) begin
      chk(prec == PRE, "R4 preamble length", prec, PRE);
      chk(sfdc == 8, "R4 delimiter length", sfdc, 8);
      chk(gb0 == 1 && gb1 == 0, "R4 generator starts 1 then 0", gb0 * 10 + gb1, 10);
    end
  endtask

  task automatic wait_code(input logic [2:0] c);
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (state_code == c) break;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b1; rx_act = '0; col_det = '0; buf_empty = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(state_code == 3'd0, "R1 state after reset", int'(state_code), 0);
    chk(tx_en == '0, "R1 tx_en after reset", int'(tx_en), 0);
    chk(!gen_en && !sfd_en && !data_en, "R1 generator idle", int'(gen_en), 0);

    // table of stimulus/expected vectors
    for (int n = 0; n < NCASE; n++) run_case(T_MASK[n], T_DUR[n]);

    // R9: drain stall keeps data state
    buf_empty = 1'b0;
    rx_act = 4'b0010;
    repeat (120) @(negedge clk);
    rx_act = '0;
    repeat (5) @(negedge clk);
    chk(state_code == 3'd2 && data_en, "R9 holds data until drained", int'(state_code), 2);
    buf_empty = 1'b1;
    @(negedge clk);
    chk(state_code == 3'd4, "R9 recovery after drain", int'(state_code), 4);
    wait_code(3'd0);
    repeat (WAITB + 1) @(negedge clk);

    // R8: collision on the source extends jam
    rx_act = 4'b0001;
    wait_code(3'd2);
    repeat (70) @(negedge clk);
    col_det = 4'b0001;
    @(negedge clk);
    chk(state_code == 3'd3, "R8 collision enters jam", int'(state_code), 3);
    repeat (200) @(negedge clk);
    chk(state_code == 3'd3 && tx_en == 4'b1111, "R8 jam held while collision", int'(state_code), 3);
    chk(state_code == 3'd3, "R11 jam code", int'(state_code), 3);
    rx_act = '0; col_det = '0;
    @(negedge clk);
    chk(state_code == 3'd4, "R8 jam ends when quiet", int'(state_code), 4);

    // R10: activity during wait is ignored
    wait_code(3'd0);
    rx_act = 4'b0100;
    begin
      int bad = 0;
      for (int j = 1; j <= WAITB - 1; j++) begin
        @(negedge clk);
        if (state_code != 3'd0) bad++;
      end
      chk(bad == 0, "R10 wait ignores activity", bad, 0);
    end
    repeat (2) @(negedge clk);
    chk(state_code == 3'd1, "R11 start-up code after wait", int'(state_code), 1);

    // R12: bit strobe gap freezes start-up
    bit_en = 1'b0;
    repeat (10) @(negedge clk);
    chk(state_code == 3'd1 && tx_en == '0, "R12 start-up frozen without strobe", int'(state_code), 1);
    bit_en = 1'b1;
    repeat (STARTUP) @(negedge clk);
    chk(state_code == 3'd2, "R11 repeat code after start-up", int'(state_code), 2);
    rx_act = '0;
    wait_code(3'd4);
    wait_code(3'd0);
    repeat (WAITB + 1) @(negedge clk);
    chk(state_code == 3'd0 && tx_en == '0, "R11 idle code at end", int'(state_code), 0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule